// File: doc/BRIEF.md
# Dithered Split-Segment PWM Engine

This block turns sixteen grayscale words into sixteen on/off enables, one per LED current sink, timed by the grayscale clock. Each word is 12 or 16 bits wide. In the default linear mode a single counter sweeps the whole word once per frame. In the three split modes the word is divided into an upper (coarse) field and a 6-bit lower (fine) field. The coarse field is compared against a short segment counter that repeats many times per frame, so the bright part of a pulse is spread over the frame and not bunched into one long burst. The fine field then gets one full-rate segment at the end of the frame. In every mode the number of on-cycles in a frame equals the grayscale word.

New words arrive on a flat, double-buffered data bus and take effect on a global-latch strobe. In automatic sync the strobe captures the words into a shadow copy, and the shadow is applied when the current frame ends. In manual sync the compare registers are updated at once. To limit inrush, channels are grouped by index modulo four, and each group's enable is delayed by a further `STEP` grayscale-clock cycles.

After reset the engine is idle with all enables off. The first global latch loads the words and starts a frame from position zero.

Top module: `dither_pwm_engine`

## Requirements
- R1: After reset all enables stay low until the first global latch. That latch loads the words and starts a frame at position 0. The first frame position reaches group-0 outputs on the second clock edge after the latch is sampled.
- R2: A channel whose grayscale word is zero is never enabled, in any mode.
- R3: With countMode = 2'b11 (linear) and 12-bit depth, the frame is 4096 cycles long. A channel is on while the frame position is less than its word, so its on-count per frame equals its word.
- R4: With countMode = 2'b00, the coarse segment (word bits [11:6] at 12-bit depth) repeats 64 times at full rate, then the fine segment (bits [5:0]) runs once. The frame is 4160 cycles, the first 64 positions carry coarse-value on-cycles, and the per-frame on-count equals the word.
- R5: With countMode = 2'b01, the coarse segment repeats 16 times, with each segment step lasting 4 clocks, then the fine segment runs once at full rate. The first 256 positions carry 4×coarse on-cycles, and the per-frame on-count equals the word.
- R6: With countMode = 2'b10, the coarse segment repeats 4 times, with each segment step lasting 16 clocks, then the fine segment runs once. The first 1024 positions carry 16×coarse on-cycles, and the per-frame on-count equals the word.
- R7: With depth16 = 1, the coarse field is bits [15:6] and the segment is 1024 steps long, with the same repeat and prescale counts. In split modes the frame is 65600 cycles and the on-count equals the word.
- R8: With syncManual = 0, a global latch while running does not change any output until the current frame ends. The captured words apply from position 0 of the next frame.
- R9: With syncManual = 1, a global latch replaces the compare words at once. The change reaches group-0 outputs on the second clock edge after the latch is sampled.
- R10: Channel i is delayed by (i mod 4)×STEP clock cycles relative to group 0.
- R11: At 12-bit depth, bits [15:12] of each word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanData | input | NCH*16 | Buffered grayscale words, channel i at bits [16i+15:16i] |
| globalLatch | input | 1 | One-cycle strobe that takes the words in |
| depth16 | input | 1 | 0: 12-bit words, 1: 16-bit words |
| countMode | input | 2 | 00/01/10 split modes with 64/16/4 repeats, 11 linear |
| syncManual | input | 1 | 1: apply the latch at once, 0: defer it to the frame end |
| chanOn | output | NCH | Per-channel output enables, staggered by group |

## Verification
On every cycle, the assertions check the following. An idle engine holds its counters at the frame start. The fine segment always runs at full rate. A deferred load in automatic sync lands exactly on a frame wrap. A zero word never produces an enable. Whole-frame properties need the bench's scenarios. These are the per-frame on-counts in each mode and depth, the distribution of coarse on-time within the first segment window, the group stagger offsets, and the visible difference between deferred and immediate latching.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int WORD_W = 16;
  localparam int LSB_W = 6;
  localparam int MSB_W_NARROW = 6;
  localparam int MSB_W_WIDE = 10;
  localparam int REP_W = 6;
  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    CM_REP64  = 2'b00,
    CM_REP16  = 2'b01,
    CM_REP4   = 2'b10,
    CM_LINEAR = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic              running;
    logic              linear;
    logic              lsbPhase;
    logic              capture;
    logic              load;
    logic [WORD_W-1:0] pos;
  } seq_strobe_t;
endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        globalLatch,
  input  logic        depth16,
  input  logic [1:0]  countMode,
  input  logic        syncManual,
  output seq_strobe_t str
);
  localparam logic [WORD_W-1:0] LSB_LAST    = WORD_W'((1 << LSB_W) - 1);
  localparam logic [WORD_W-1:0] NARROW_LAST = WORD_W'((1 << MSB_W_NARROW) - 1);
  localparam logic [WORD_W-1:0] WIDE_LAST   = WORD_W'((1 << MSB_W_WIDE) - 1);
  localparam logic [WORD_W-1:0] LIN12_LAST  = WORD_W'((1 << (MSB_W_NARROW + LSB_W)) - 1);
  localparam logic [WORD_W-1:0] LIN16_LAST  = '1;

  logic              running, lsbPhase, pending;
  logic [WORD_W-1:0] pos, segMax;
  logic [PRE_W-1:0]  preCnt, preMax;
  logic [REP_W-1:0]  repCnt, repMax;
  logic              linear, tick, segDone, frameEnd, load;

  assign linear = (cnt_mode_e'(countMode) == CM_LINEAR);

  always_comb begin
    unique case (cnt_mode_e'(countMode))
      CM_REP64: begin preMax = PRE_W'(0);  repMax = REP_W'(63); end
      CM_REP16: begin preMax = PRE_W'(3);  repMax = REP_W'(15); end
      CM_REP4:  begin preMax = PRE_W'(15); repMax = REP_W'(3);  end
      default:  begin preMax = PRE_W'(0);  repMax = REP_W'(0);  end
    endcase
    if (linear)        segMax = depth16 ? LIN16_LAST : LIN12_LAST;
    else if (lsbPhase) segMax = LSB_LAST;
    else               segMax = depth16 ? WIDE_LAST : NARROW_LAST;
  end

  assign tick     = linear || lsbPhase || (preCnt == preMax);
  assign segDone  = tick && (pos == segMax);
  assign frameEnd = running && segDone && (linear || lsbPhase);
  assign load     = (globalLatch && (!running || syncManual))
                  || (frameEnd && (pending || globalLatch));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      lsbPhase <= 1'b0;
      pending  <= 1'b0;
      pos      <= '0;
      preCnt   <= '0;
      repCnt   <= '0;
    end else begin
      if (globalLatch) running <= 1'b1;
      if (running) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) pos <= segDone ? '0 : pos + 1'b1;
        if (segDone && !linear) begin
          if (lsbPhase) lsbPhase <= 1'b0;
          else if (repCnt == repMax) begin
            repCnt   <= '0;
            lsbPhase <= 1'b1;
          end else repCnt <= repCnt + 1'b1;
        end
      end
      if (load) pending <= 1'b0;
      else if (globalLatch && running && !syncManual) pending <= 1'b1;
    end
  end

  assign str = '{running: running, linear: linear, lsbPhase: lsbPhase,
                 capture: globalLatch, load: load, pos: pos};

  // R1
  idle_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pos == '0 && !lsbPhase && repCnt == '0));
  // R4
  fine_full_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsbPhase |-> preCnt == '0);
  // R8
  deferred_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (load && running && !syncManual) |=> pos == '0);
endmodule

// File: rtl/dpwm_datapath.sv
module dpwm_datapath
  import dpwm_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int STEP = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH*WORD_W-1:0]   chanData,
  input  logic                    depth16,
  input  seq_strobe_t             str,
  output logic [NCH-1:0]          chanOn
);
  localparam int NARROW_TOP = MSB_W_NARROW + LSB_W;

  logic [WORD_W-1:0] shadow [NCH];
  logic [WORD_W-1:0] cmp    [NCH];
  logic [NCH-1:0]    hit, onRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        shadow[i] <= '0;
        cmp[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (str.capture) shadow[i] <= chanData[i*WORD_W +: WORD_W];
        if (str.load)
          cmp[i] <= str.capture ? chanData[i*WORD_W +: WORD_W] : shadow[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) onRaw <= '0;
    else       onRaw <= str.running ? hit : '0;
  end

  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.running |=> onRaw == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int DLY = (i % 4) * STEP;
    logic [WORD_W-1:0] segVal;

    always_comb begin
      if (str.linear)
        segVal = depth16 ? cmp[i] : WORD_W'(cmp[i][NARROW_TOP-1:0]);
      else if (str.lsbPhase)
        segVal = WORD_W'(cmp[i][LSB_W-1:0]);
      else if (depth16)
        segVal = WORD_W'(cmp[i][LSB_W +: MSB_W_WIDE]);
      else
        segVal = WORD_W'(cmp[i][LSB_W +: MSB_W_NARROW]);
    end
    assign hit[i] = (str.pos < segVal);

    // R2
    zero_stays_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmp[i] == '0) |=> !onRaw[i]);

    if (DLY == 0) begin : g_direct
      assign chanOn[i] = onRaw[i];
    end else begin : g_stagger
      logic [DLY-1:0] pipe;
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= (pipe << 1) | DLY'(onRaw[i]);
      end
      assign chanOn[i] = pipe[DLY-1];
    end
  end
endmodule

// File: rtl/dither_pwm_engine.sv
module dither_pwm_engine
  import dpwm_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int STEP = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH*WORD_W-1:0] chanData,
  input  logic                  globalLatch,
  input  logic                  depth16,
  input  logic [1:0]            countMode,
  input  logic                  syncManual,
  output logic [NCH-1:0]        chanOn
);
  seq_strobe_t seqStr;

  dpwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .globalLatch(globalLatch), .depth16(depth16),
    .countMode(countMode), .syncManual(syncManual), .str(seqStr)
  );

  dpwm_datapath #(.NCH(NCH), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .chanData(chanData), .depth16(depth16),
    .str(seqStr), .chanOn(chanOn)
  );
endmodule

// File: tb/dither_pwm_engine_tb.sv
module dither_pwm_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int STEP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH*16-1:0] chanData = '0;
  logic globalLatch = 1'b0;
  logic depth16 = 1'b0;
  logic syncManual = 1'b0;
  logic [1:0] countMode = 2'b11;
  logic [NCH-1:0] chanOn;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_pwm_engine #(.NCH(NCH), .STEP(STEP)) u_dut (
    .clk(clk), .rstN(rstN), .chanData(chanData), .globalLatch(globalLatch),
    .depth16(depth16), .countMode(countMode), .syncManual(syncManual),
    .chanOn(chanOn)
  );

  typedef struct {
    int    ch;
    int    kind;   // 0 frame on-count, 1 first-on sample, 2 first-segment on-count
    int    expv;
    string tag;
  } exp_t;

  exp_t sbQ[$];
  int   vals[NCH];
  int   nRun = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  task automatic check(string tag, int act, int expv);
    nRun++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(logic d16, logic [1:0] m, logic man);
    @(negedge clk);
    rstN = 1'b0; globalLatch = 1'b0;
    depth16 = d16; countMode = m; syncManual = man;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_val(int ch, int v);
    vals[ch] = v;
    chanData[ch*16 +: 16] = v[15:0];
  endtask

  task automatic load_vals(int seed, bit d16);
    for (int i = 0; i < NCH; i++) begin
      int v;
      if (d16) v = (seed*4099 + i*5003 + 77) & 'hFFFF;
      else     v = (seed*37 + i*263 + 5) % 4096;
      if (i < 4) v = v | 64;
      if (i == 5) v = 0;
      if (!d16 && i == 9) v = v | 'hA000;
      set_val(i, v);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after the sampling edge
  task automatic pulse_latch();
    globalLatch = 1'b1;
    @(negedge clk);
    globalLatch = 1'b0;
  endtask

  // driver: push expectations for one frame
  task automatic push_expect(bit d16, logic [1:0] m);
    for (int i = 0; i < NCH; i++) begin
      int tot, p;
      string tg;
      tot = d16 ? vals[i] : (vals[i] & 'hFFF);
      if (i == 5)       tg = "R2";
      else if (m == 3)  tg = (i == 9) ? "R11" : "R3";
      else if (d16)     tg = "R7";
      else              tg = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
      sbQ.push_back('{i, 0, tot, tg});
      if (i < 4) sbQ.push_back('{i, 1, (i % 4) * STEP, (i == 0) ? "R1" : "R10"});
      if (m != 3) begin
        p = (m == 0) ? 1 : (m == 1) ? 4 : 16;
        sbQ.push_back('{i, 2, (tot >> 6) * p, tg});
      end
    end
  endtask

  // monitor: observe one frame per channel and pop/compare expectations
  task automatic monitor_frame(int frameLen, int segWin);
    int onC[NCH], segC[NCH], first[NCH];
    for (int i = 0; i < NCH; i++) begin onC[i] = 0; segC[i] = 0; first[i] = -1; end
    for (int k = 0; k < frameLen + 3*STEP; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        int off;
        off = (i % 4) * STEP;
        if (chanOn[i]) begin
          if (first[i] < 0) first[i] = k;
          if (k >= off && k < off + frameLen) onC[i]++;
          if (k >= off && k < off + segWin) segC[i]++;
        end
      end
    end
    while (sbQ.size() > 0) begin
      exp_t e;
      int a;
      e = sbQ.pop_front();
      a = (e.kind == 0) ? onC[e.ch] : (e.kind == 1) ? first[e.ch] : segC[e.ch];
      check($sformatf("%s ch%0d kind%0d", e.tag, e.ch, e.kind), a, e.expv);
    end
  endtask

  task automatic run_frame(int seed, bit d16, logic [1:0] m);
    int frameLen, segWin, p;
    do_reset(d16, m, 1'b0);
    load_vals(seed, d16);
    p = (m == 0) ? 1 : (m == 1) ? 4 : 16;
    if (m == 3) begin frameLen = d16 ? 65536 : 4096; segWin = 0; end
    else begin
      frameLen = d16 ? 65600 : 4160;
      segWin = (d16 ? 1024 : 64) * p;
    end
    push_expect(d16, m);
    pulse_latch();
    monitor_frame(frameLen, segWin);
  endtask

  initial begin
    int cnt, w;
    // R1: idle after reset even with data present
    do_reset(1'b0, 2'b11, 1'b0);
    load_vals(3, 1'b0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (chanOn != '0) cnt++;
    end
    check("R1 idle before first latch", cnt, 0);

    run_frame(1, 1'b0, 2'b11);
    run_frame(2, 1'b0, 2'b00);
    run_frame(3, 1'b0, 2'b01);
    run_frame(4, 1'b0, 2'b10);

    // R8 / R9 sync behaviour, linear 12-bit
    do_reset(1'b0, 2'b11, 1'b0);
    load_vals(5, 1'b0);
    set_val(0, 5);
    pulse_latch();
    repeat (1000) @(negedge clk);
    set_val(0, 4095);
    pulse_latch();
    cnt = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (chanOn[0]) cnt++;
    end
    check("R8 deferred latch leaves ch0 dark", cnt, 0);
    w = 0;
    while (!chanOn[0] && w < 5000) begin @(negedge clk); w++; end
    check("R8 new word applied at next frame", int'(chanOn[0]), 1);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (chanOn[0]) cnt++;
    end
    check("R8 new word held on", cnt, 100);
    syncManual = 1'b1;
    set_val(0, 0);
    check("R9 ch0 on before manual latch", int'(chanOn[0]), 1);
    pulse_latch();
    @(negedge clk);
    check("R9 manual latch takes effect at once", int'(chanOn[0]), 0);

    run_frame(6, 1'b1, 2'b01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule